// File: doc/BRIEF.md
# Scanout Timing Generator with Double-Buffered Frame Base

This block produces the raster timing for one display scanout pipe. It advances one pixel per clock. A horizontal counter runs across each line and a vertical counter steps once per line. From those two counters the block decodes the data-enable window and the horizontal and vertical sync pulses. Software sets, through a small word-addressed register port, the active and total size of each axis and the start, end, enable and polarity of each sync pulse. An output-enable bit and an active-low run bit control the pipe.

Two frame-base address registers are held. One of them drives the `frame_base` output, and a read-only bit shows which one that is. A flip request does not swap the buffers at once. It is held pending and is applied on the edge that moves the raster to the first line below the active picture. That same edge raises a one-cycle vblank pulse, which serves as the interrupt source, and advances a vblank counter. Software can read the live beam position and the vblank count. A 1-to-0 transition of the run bit soft-resets the pipe.

Top module: `scanout_timing`

## Requirements
- R1: The register port is word-addressed and writes take effect on the clock edge where `reg_we` is high. The addresses are 0 control, 1 horizontal timing, 2 horizontal sync, 3 vertical timing, 4 vertical sync, 5 frame base 0, 6 frame base 1, 7 position (read-only) and 8 vblank count (read-only). In the timing words, bits [15:0] hold the active size and bits [31:16] hold the total size. While the run bit (control bit 1) is 1, X steps by one each clock and wraps from total-1 to 0. Y steps when X wraps and itself wraps from vertical total-1 to 0.
- R2: Reading address 7 returns the current X in bits [31:16] and the current Y in bits [15:0]. The read data is combinational from `reg_addr`.
- R3: `de` is high exactly when X is below the horizontal active size, Y is below the vertical active size, and output enable (control bit 0) is 1.
- R4: In a sync word, bits [13:0] hold start, bits [27:14] hold end, bit 30 is enable and bit 31 is invert. The raw pulse is high when enable is 1 and start <= count < end. The output is the raw pulse XOR invert, so with enable 0 the output sits at the invert value.
- R5: While output enable is 0, `de` is 0 and `hsync` and `vsync` each sit at their invert bit value. Counting and the vblank pulse continue.
- R6: `vblank_pulse` is high for exactly the one cycle in which the counters are at X=0 and Y equal to the vertical active size.
- R7: The vblank count (address 8) increments by one on the edge that raises `vblank_pulse`. It holds at all other times.
- R8: `frame_base` equals frame base 0 while the in-use bit (control bit 3, read-only) is 0, and equals frame base 1 while it is 1.
- R9: Writing control with bit 2 set requests a flip and sets the pending bit (control bit 4, read-only). The in-use bit does not change until the next vblank edge. On that edge it toggles and pending clears. A second request after a completed flip returns to the other buffer.
- R10: A flip requested after a vblank edge, including one written on the vblank edge itself, stays pending. It is applied at the following vblank edge, and the in-use bit holds until then.
- R11: A control write with bit 1 at 0 while the run bit is 1 clears the position, the vblank count, the in-use bit and the pending bit. While the run bit stays 0 the position holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| frame_base | output | FB_W | Frame base address in use |
| vblank_pulse | output | 1 | One-cycle pulse at start of vertical blank |

## Verification
A corrupted counter shows up on the very next clock at the position register. Within one line it also shows as misplaced `de` and sync edges. A wrong pending or in-use state appears on `frame_base` and in the control readback no later than the next vblank edge, which is at most one frame away. A flip taken too early or too late is therefore caught within one frame. A miscounted vblank counter differs from the bench's own tally at the first pulse after the error.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

  localparam int DATA_W = 32;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 4'd0,
    RA_HTIME = 4'd1,
    RA_HSYNC = 4'd2,
    RA_VTIME = 4'd3,
    RA_VSYNC = 4'd4,
    RA_FB0   = 4'd5,
    RA_FB1   = 4'd6,
    RA_POS   = 4'd7,
    RA_VBCNT = 4'd8
  } reg_addr_e;

  // control word bit positions
  localparam int CTL_OE    = 0;
  localparam int CTL_RUN   = 1;
  localparam int CTL_FLIP  = 2;
  localparam int CTL_INUSE = 3;
  localparam int CTL_PEND  = 4;

  localparam int SY_FIELD_W = 14;

  typedef struct packed {
    logic [15:0] total;
    logic [15:0] active;
  } axis_tm_t;

  typedef struct packed {
    logic                  inv;
    logic                  en;
    logic [1:0]            rsvd;
    logic [SY_FIELD_W-1:0] stop;
    logic [SY_FIELD_W-1:0] start;
  } sync_cfg_t;

endpackage

// File: rtl/tg_axis_counter.sv
module tg_axis_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [15:0]      total,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic [15:0]      last;
  logic             at_last;

  assign last    = total - 16'd1;
  assign at_last = (16'(cnt_q) == last);
  assign wrap    = step && at_last;

  always_comb begin
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (step) begin
      if (at_last) cnt_n = '0;
      else         cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tg_sync_gen.sv
module tg_sync_gen
  import scanout_pkg::*;
(
  input  logic       [15:0] pos,
  input  sync_cfg_t         cfg,
  input  logic       [15:0] active,
  input  logic              oe,
  output logic              sync_o,
  output logic              in_act
);

  logic [15:0] st16;
  logic [15:0] sp16;
  logic        in_win;
  logic        raw;

  assign st16   = 16'(cfg.start);
  assign sp16   = 16'(cfg.stop);
  assign in_win = (pos >= st16) && (pos < sp16);
  assign raw    = cfg.en && in_win;
  assign sync_o = oe ? (raw ^ cfg.inv) : cfg.inv;
  assign in_act = (pos < active);

endmodule

// File: rtl/tg_flip_ctl.sv
module tg_flip_ctl #(
  parameter int VBC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             flip_wr,
  input  logic             vb_edge,
  output logic             in_use,
  output logic             pending,
  output logic [VBC_W-1:0] vbcnt,
  output logic             vb_pulse
);

  logic             in_use_q,  in_use_n;
  logic             pend_q,    pend_n;
  logic [VBC_W-1:0] vbcnt_q,   vbcnt_n;
  logic             pulse_q,   pulse_n;
  logic             vb_take;

  assign vb_take = vb_edge && !soft_clr;

  always_comb begin
    in_use_n = in_use_q;
    pend_n   = pend_q;
    vbcnt_n  = vbcnt_q;
    pulse_n  = vb_take;
    if (soft_clr) begin
      in_use_n = 1'b0;
      pend_n   = 1'b0;
      vbcnt_n  = '0;
    end else if (vb_take) begin
      // the request seen before this edge is applied; a new one waits
      if (pend_q) in_use_n = ~in_use_q;
      pend_n  = flip_wr;
      vbcnt_n = vbcnt_q + 1'b1;
    end else if (flip_wr) begin
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_use_q <= 1'b0;
      pend_q   <= 1'b0;
      vbcnt_q  <= '0;
      pulse_q  <= 1'b0;
    end else begin
      in_use_q <= in_use_n;
      pend_q   <= pend_n;
      vbcnt_q  <= vbcnt_n;
      pulse_q  <= pulse_n;
    end
  end

  assign in_use   = in_use_q;
  assign pending  = pend_q;
  assign vbcnt    = vbcnt_q;
  assign vb_pulse = pulse_q;

endmodule

// File: rtl/tg_regs.sv
module tg_regs
  import scanout_pkg::*;
#(
  parameter int FB_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic       [REG_AW-1:0] addr,
  input  logic       [DATA_W-1:0] wdata,
  output logic       [DATA_W-1:0] rdata,
  input  logic       [15:0]       pos_x,
  input  logic       [15:0]       pos_y,
  input  logic       [DATA_W-1:0] vbcnt,
  input  logic                    in_use,
  input  logic                    pending,
  output logic                    oe,
  output logic                    run,
  output axis_tm_t   [1:0]        tm,
  output sync_cfg_t  [1:0]        sy,
  output logic       [FB_W-1:0]   fb0,
  output logic       [FB_W-1:0]   fb1,
  output logic                    soft_clr,
  output logic                    flip_wr
);

  logic                 oe_q,  oe_n;
  logic                 run_q, run_n;
  axis_tm_t  [1:0]      tm_q,  tm_n;
  sync_cfg_t [1:0]      sy_q,  sy_n;
  logic      [FB_W-1:0] fb0_q, fb0_n;
  logic      [FB_W-1:0] fb1_q, fb1_n;
  logic                 ctrl_wr;

  assign ctrl_wr  = we && (addr == RA_CTRL);
  assign soft_clr = ctrl_wr && !wdata[CTL_RUN] && run_q;
  assign flip_wr  = ctrl_wr && wdata[CTL_FLIP];

  always_comb begin
    oe_n  = oe_q;
    run_n = run_q;
    tm_n  = tm_q;
    sy_n  = sy_q;
    fb0_n = fb0_q;
    fb1_n = fb1_q;
    if (we) begin
      case (addr)
        RA_CTRL: begin
          oe_n  = wdata[CTL_OE];
          run_n = wdata[CTL_RUN];
        end
        RA_HTIME: tm_n[0] = axis_tm_t'(wdata);
        RA_HSYNC: sy_n[0] = sync_cfg_t'(wdata);
        RA_VTIME: tm_n[1] = axis_tm_t'(wdata);
        RA_VSYNC: sy_n[1] = sync_cfg_t'(wdata);
        RA_FB0:   fb0_n   = wdata[FB_W-1:0];
        RA_FB1:   fb1_n   = wdata[FB_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      run_q <= 1'b0;
      tm_q  <= '0;
      sy_q  <= '0;
      fb0_q <= '0;
      fb1_q <= '0;
    end else begin
      oe_q  <= oe_n;
      run_q <= run_n;
      tm_q  <= tm_n;
      sy_q  <= sy_n;
      fb0_q <= fb0_n;
      fb1_q <= fb1_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[CTL_OE]    = oe_q;
        rdata[CTL_RUN]   = run_q;
        rdata[CTL_INUSE] = in_use;
        rdata[CTL_PEND]  = pending;
      end
      RA_HTIME: rdata = tm_q[0];
      RA_HSYNC: rdata = sy_q[0];
      RA_VTIME: rdata = tm_q[1];
      RA_VSYNC: rdata = sy_q[1];
      RA_FB0:   rdata = DATA_W'(fb0_q);
      RA_FB1:   rdata = DATA_W'(fb1_q);
      RA_POS:   rdata = {pos_x, pos_y};
      RA_VBCNT: rdata = vbcnt;
      default:  rdata = '0;
    endcase
  end

  assign oe  = oe_q;
  assign run = run_q;
  assign tm  = tm_q;
  assign sy  = sy_q;
  assign fb0 = fb0_q;
  assign fb1 = fb1_q;

endmodule

// File: rtl/scanout_timing.sv
module scanout_timing
  import scanout_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int FB_W  = 32,
  parameter int VBC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 de,
  output logic [FB_W-1:0]      frame_base,
  output logic                 vblank_pulse
);

  localparam int NAXIS = 2;

  logic                   oe;
  logic                   run;
  axis_tm_t  [NAXIS-1:0]  tm;
  sync_cfg_t [NAXIS-1:0]  sy;
  logic      [FB_W-1:0]   fb0;
  logic      [FB_W-1:0]   fb1;
  logic                   soft_clr;
  logic                   flip_wr;
  logic                   in_use;
  logic                   pending;
  logic      [VBC_W-1:0]  vbcnt;

  logic      [CNT_W-1:0]  h_cnt;
  logic      [CNT_W-1:0]  v_cnt;
  logic                   h_wrap;
  logic                   v_wrap;
  logic      [15:0]       pos_x16;
  logic      [15:0]       pos_y16;
  logic [NAXIS-1:0][15:0] pos_ax;
  logic      [NAXIS-1:0]  sync_ax;
  logic      [NAXIS-1:0]  act_ax;
  logic                   vb_edge;

  tg_regs #(.FB_W(FB_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .pos_x    (pos_x16),
    .pos_y    (pos_y16),
    .vbcnt    (DATA_W'(vbcnt)),
    .in_use   (in_use),
    .pending  (pending),
    .oe       (oe),
    .run      (run),
    .tm       (tm),
    .sy       (sy),
    .fb0      (fb0),
    .fb1      (fb1),
    .soft_clr (soft_clr),
    .flip_wr  (flip_wr)
  );

  tg_axis_counter #(.CNT_W(CNT_W)) u_hcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_clr),
    .step  (run),
    .total (tm[0].total),
    .cnt   (h_cnt),
    .wrap  (h_wrap)
  );

  tg_axis_counter #(.CNT_W(CNT_W)) u_vcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_clr),
    .step  (h_wrap),
    .total (tm[1].total),
    .cnt   (v_cnt),
    .wrap  (v_wrap)
  );

  assign pos_x16   = 16'(h_cnt);
  assign pos_y16   = 16'(v_cnt);
  assign pos_ax[0] = pos_x16;
  assign pos_ax[1] = pos_y16;

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    tg_sync_gen u_sync (
      .pos    (pos_ax[a]),
      .cfg    (sy[a]),
      .active (tm[a].active),
      .oe     (oe),
      .sync_o (sync_ax[a]),
      .in_act (act_ax[a])
    );
  end

  // edge that lands on the first line below the active picture
  assign vb_edge = h_wrap && !v_wrap && (pos_y16 == (tm[1].active - 16'd1));

  tg_flip_ctl #(.VBC_W(VBC_W)) u_flip (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .flip_wr  (flip_wr),
    .vb_edge  (vb_edge),
    .in_use   (in_use),
    .pending  (pending),
    .vbcnt    (vbcnt),
    .vb_pulse (vblank_pulse)
  );

  assign hsync      = sync_ax[0];
  assign vsync      = sync_ax[1];
  assign de         = oe && (&act_ax);
  assign frame_base = in_use ? fb1 : fb0;

endmodule

// File: rtl/scanout_timing_chk.sv
module scanout_timing_chk #(
  parameter int VBC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vblank_pulse,
  input logic             in_use,
  input logic             pending,
  input logic [VBC_W-1:0] vbcnt,
  input logic             soft_clr,
  input logic             flip_wr,
  input logic [15:0]      pos_x16,
  input logic [15:0]      pos_y16
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |=> !vblank_pulse); // R6

  AST_INUSE_AT_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_use != $past(in_use)) |-> (vblank_pulse || $past(soft_clr))); // R9

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_pulse && !$past(flip_wr)) |-> !pending); // R9

  AST_LATE_FLIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_pulse && $past(flip_wr)) |-> pending); // R10

  AST_VBCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |-> (vbcnt == VBC_W'($past(vbcnt) + 1'b1))); // R7

  AST_VBCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vblank_pulse && !$past(soft_clr)) |-> $stable(vbcnt)); // R7

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_clr) |-> (pos_x16 == 16'd0 && pos_y16 == 16'd0 &&
                         vbcnt == '0 && !in_use && !pending)); // R11

endmodule

bind scanout_timing scanout_timing_chk #(.VBC_W(VBC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vblank_pulse (vblank_pulse),
  .in_use       (in_use),
  .pending      (pending),
  .vbcnt        (vbcnt),
  .soft_clr     (soft_clr),
  .flip_wr      (flip_wr),
  .pos_x16      (pos_x16),
  .pos_y16      (pos_y16)
);

// File: tb/scanout_timing_test.sv
module scanout_timing_test;

  localparam int HACT = 8,  HTOT = 12, HS_ST = 9, HS_SP = 11;
  localparam int VACT = 4,  VTOT = 6,  VS_ST = 4, VS_SP = 5;
  localparam int FRAME = HTOT * VTOT;
  localparam logic [31:0] BASE_A = 32'h1000_0000;
  localparam logic [31:0] BASE_B = 32'h2000_4000;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        hsync, vsync, de, vblank_pulse;
  logic [31:0] frame_base;

  int n_chk;
  int n_bad;
  bit done;

  // bench copy of the programmed sync settings
  bit h_en, h_inv, v_en, v_inv, out_en;

  scanout_timing uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .hsync        (hsync),
    .vsync        (vsync),
    .de           (de),
    .frame_base   (frame_base),
    .vblank_pulse (vblank_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_sync(int st, int sp, bit en, bit inv);
    return {inv, en, 2'b00, 14'(sp), 14'(st)};
  endfunction

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_pos(input int x, input int y);
    logic [31:0] p;
    for (int i = 0; i < 4 * FRAME; i++) begin
      rd(4'd7, p);
      if (p[31:16] == 16'(x) && p[15:0] == 16'(y)) return;
      step(1);
    end
    chk("R1", "position never reached", 0, 1);
  endtask

  // advances at least one cycle; counts in_use changes before the pulse
  task automatic wait_pulse(output int changes);
    logic [31:0] c;
    bit first_iu, seen;
    rd(4'd0, c); first_iu = c[3]; changes = 0; seen = 0;
    for (int i = 0; i < 4 * FRAME; i++) begin
      step(1);
      if (vblank_pulse) begin seen = 1; break; end
      rd(4'd0, c);
      if (c[3] != first_iu) changes++;
    end
    if (!seen) chk("R6", "vblank pulse missing", 0, 1);
  endtask

  task automatic prog_sync();
    wr(4'd2, mk_sync(HS_ST, HS_SP, h_en, h_inv));
    wr(4'd4, mk_sync(VS_ST, VS_SP, v_en, v_inv));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R5", "hsync at reset", hsync, 0);
    chk("R5", "vsync at reset", vsync, 0);
    chk("R3", "de at reset", de, 0);
    chk("R6", "pulse at reset", vblank_pulse, 0);
    chk("R8", "frame_base at reset", frame_base, 0);
    rd(4'd0, d); chk("R9", "ctrl at reset", d, 0);
    rd(4'd7, d); chk("R2", "position at reset", d, 0);
    rd(4'd8, d); chk("R7", "vblank count at reset", d, 0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    h_en = 1; h_inv = 0; v_en = 1; v_inv = 0; out_en = 1;
    wr(4'd1, {16'(HTOT), 16'(HACT)});
    wr(4'd3, {16'(VTOT), 16'(VACT)});
    prog_sync();
    wr(4'd5, BASE_A);
    wr(4'd6, BASE_B);
    rd(4'd1, d); chk("R1", "horizontal timing readback", d, {16'(HTOT), 16'(HACT)});
    chk("R8", "frame_base selects base 0", frame_base, BASE_A);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(4'd0, 32'h3);
    rd(4'd7, d); chk("R2", "position after start", d, 0);
    step(5);
    rd(4'd7, d); chk("R1", "X after 5 clocks", d, {16'd5, 16'd0});
    step(HTOT);
    rd(4'd7, d); chk("R1", "Y after one line", d, {16'd5, 16'd1});
  endtask

  // one frame, each output compared against the live position
  task automatic t_scan(input string tag);
    logic [31:0] p;
    int x, y, px, py;
    bit ed, eh, ev;
    for (int i = 0; i < FRAME + 2; i++) begin
      rd(4'd7, p);
      x = int'(p[31:16]); y = int'(p[15:0]);
      if (i > 0) begin
        chk("R1", {tag, " X sequence"}, x, (px == HTOT - 1) ? 0 : px + 1);
        chk("R1", {tag, " Y sequence"}, y,
            (px == HTOT - 1) ? ((py == VTOT - 1) ? 0 : py + 1) : py);
      end
      ed = out_en && (x < HACT) && (y < VACT);
      eh = out_en ? ((h_en && x >= HS_ST && x < HS_SP) ^ h_inv) : h_inv;
      ev = out_en ? ((v_en && y >= VS_ST && y < VS_SP) ^ v_inv) : v_inv;
      chk(out_en ? "R3" : "R5", {tag, " de"}, de, ed);
      chk(out_en ? "R4" : "R5", {tag, " hsync"}, hsync, eh);
      chk(out_en ? "R4" : "R5", {tag, " vsync"}, vsync, ev);
      chk("R6", {tag, " vblank pulse"}, vblank_pulse, (x == 0 && y == VACT));
      px = x; py = y;
      step(1);
    end
  endtask

  task automatic t_polarity();
    h_en = 1; h_inv = 1; v_en = 0; v_inv = 0;
    prog_sync();
    t_scan("R4 hinv vdis");
    h_en = 0; h_inv = 0; v_en = 0; v_inv = 1;
    prog_sync();
    t_scan("R4 hdis vinv");
  endtask

  task automatic t_out_disable();
    h_en = 1; h_inv = 1; v_en = 1; v_inv = 0; out_en = 0;
    prog_sync();
    wr(4'd0, 32'h2);
    t_scan("R5 oe off");
    h_en = 1; h_inv = 0; v_en = 1; v_inv = 0; out_en = 1;
    prog_sync();
    wr(4'd0, 32'h3);
  endtask

  task automatic t_vbcount();
    logic [31:0] c0, c1;
    int ch;
    wait_pos(3, 1);
    rd(4'd8, c0);
    wait_pulse(ch);
    rd(4'd8, c1); chk("R7", "count at first pulse", c1, c0 + 1);
    step(7);
    rd(4'd8, c1); chk("R7", "count holds after pulse", c1, c0 + 1);
    wait_pulse(ch);
    rd(4'd8, c1); chk("R7", "count at second pulse", c1, c0 + 2);
  endtask

  task automatic t_flip();
    logic [31:0] c;
    int ch;
    wait_pos(3, 1);
    wr(4'd0, 32'h7);
    rd(4'd0, c);
    chk("R9", "pending after request", c[4], 1);
    chk("R9", "in_use before vblank", c[3], 0);
    chk("R8", "base before vblank", frame_base, BASE_A);
    wait_pulse(ch);
    chk("R9", "in_use held until vblank", ch, 0);
    rd(4'd0, c);
    chk("R9", "in_use after vblank", c[3], 1);
    chk("R9", "pending cleared", c[4], 0);
    chk("R8", "base after flip", frame_base, BASE_B);
    wait_pos(6, 2);
    wr(4'd0, 32'h7);
    wait_pulse(ch);
    rd(4'd0, c);
    chk("R9", "second flip returns", c[3], 0);
    chk("R8", "base back to 0", frame_base, BASE_A);
  endtask

  task automatic t_flip_late();
    logic [31:0] c;
    int ch;
    wait_pulse(ch);
    step(1);
    wr(4'd0, 32'h7);
    rd(4'd0, c);
    chk("R10", "late request pending", c[4], 1);
    chk("R10", "late request not applied", c[3], 0);
    wait_pulse(ch);
    chk("R10", "in_use held for a frame", ch, 0);
    rd(4'd0, c);
    chk("R10", "late flip applied", c[3], 1);
    chk("R8", "late flip base", frame_base, BASE_B);
    // request written on the vblank edge itself
    wait_pos(HTOT - 1, VACT - 1);
    wr(4'd0, 32'h7);
    chk("R6", "pulse on edge write", vblank_pulse, 1);
    rd(4'd0, c);
    chk("R10", "edge request not applied", c[3], 1);
    chk("R10", "edge request pending", c[4], 1);
    wait_pulse(ch);
    chk("R10", "in_use held after edge write", ch, 0);
    rd(4'd0, c);
    chk("R10", "edge flip applied next frame", c[3], 0);
    chk("R8", "edge flip base", frame_base, BASE_A);
  endtask

  task automatic t_soft_reset();
    logic [31:0] c;
    int ch;
    wait_pos(3, 1);
    wr(4'd0, 32'h7);
    wait_pulse(ch);
    wait_pos(2, 0);
    wr(4'd0, 32'h7);
    rd(4'd0, c);
    chk("R11", "setup in_use", c[3], 1);
    chk("R11", "setup pending", c[4], 1);
    wr(4'd0, 32'h1);
    rd(4'd7, c); chk("R11", "position cleared", c, 0);
    rd(4'd8, c); chk("R11", "vblank count cleared", c, 0);
    rd(4'd0, c); chk("R11", "ctrl after soft reset", c, 32'h1);
    chk("R8", "base after soft reset", frame_base, BASE_A);
    step(20);
    rd(4'd7, c); chk("R11", "position holds while stopped", c, 0);
    chk("R6", "no pulse while stopped", vblank_pulse, 0);
    wr(4'd0, 32'h3);
    step(3);
    rd(4'd7, c); chk("R1", "counting resumes", c, {16'd3, 16'd0});
  endtask

  initial begin
    done = 0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset();
    t_config();
    t_count();
    t_scan("R3 normal");
    t_polarity();
    h_en = 1; h_inv = 0; v_en = 1; v_inv = 0;
    prog_sync();
    t_out_disable();
    t_vbcount();
    t_flip();
    t_flip_late();
    t_soft_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule